// File: doc/BRIEF.md
# DSI Video-Mode Timing Generator

This block paces the video stream of a DSI host running in video mode. It keeps two counters: a byte-clock counter that runs across each line, and a line counter that runs across each frame. From these counters it reports which horizontal phase and which vertical period the stream is in. It also raises a data-enable flag and presents the active packet width in pixels while a displayable line is being sent. The packet assembler and the lane serializer that follow it read these outputs.

The horizontal settings use mixed units. Sync width, back porch and total line length are given in lane byte clocks. The active width is given in pixels. The generator turns the pixel width into byte clocks by adding up the bytes the lanes carry, three bytes per pixel. The front porch is never programmed: it is whatever is left of the line after the sync, back porch and active parts. The vertical settings are four line counts.

The sync outputs take a polarity setting and a video-mode type. The type chooses between full-width sync pulses and single-cycle sync-start markers. Timing runs only while the core is powered up and video mode is selected.

Top module: `dsi_vid_timing`

## Requirements
- R1: While `power_up` is 0 or `cmd_mode` is 1 (command mode), the block is idle. In that state `vid_on`, `de` and `frame_start` are 0, `act_pixels`, `h_phase` and `v_phase` are 0, and `hsync`/`vsync` sit at their inactive level (the matching polarity bit). When running starts again, output begins at the first byte clock of a frame.
- R2: A line lasts `hline_time` byte clocks; a value of 0 is treated as 1. The horizontal count returns to zero on the byte clock after the last one of the line.
- R3: `h_phase` uses the codes 0 = sync, 1 = back porch, 2 = active, 3 = front porch. Sync covers the first `hsa_time` byte clocks of the line. Back porch covers the next `hbp_time` byte clocks.
- R4: The active phase follows the back porch and lasts ceil(`pkt_size`·3 / lanes) byte clocks, where lanes = `lane_sel`+1. It is cut short at the end of the line. The rest of the line is front porch.
- R5: `v_phase` uses the same codes (sync, back porch, active, front porch) and steps through them in that order. Each period lasts its programmed number of lines. A period programmed to zero lines is skipped. After the front porch the sequence wraps back to sync.
- R6: A vertical sync setting above 15 lines behaves as exactly 15 lines.
- R7: `de` is 1 only when both the vertical period and the horizontal phase are active. `act_pixels` equals `pkt_size` on every byte clock of a vertically active line and is 0 otherwise.
- R8: For `vmode` 0, 2 and 3, the un-inverted hsync is high for the whole horizontal sync phase, and the un-inverted vsync is high for all vertical sync lines. For `vmode` 1 (sync events), hsync is a marker on the first byte clock of each line, and vsync is a marker on the first byte clock of the first vertical sync line.
- R9: `pol_cfg` bit 2 inverts `hsync` and bit 1 inverts `vsync`. Bit 0 has no effect.
- R10: `frame_start` is high for exactly the first byte clock of each frame. That is the first line of the sync period, or of the first non-empty period if the sync period is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_up | input | 1 | Core power-up enable |
| cmd_mode | input | 1 | 0 = video mode, 1 = command mode |
| vmode | input | 2 | Video-mode type: 0 pulses, 1 events, 2/3 burst |
| pol_cfg | input | 3 | Bit 2 inverts hsync, bit 1 inverts vsync |
| lane_sel | input | LANE_W | Number of data lanes minus one |
| hsa_time | input | HW | Horizontal sync width in byte clocks |
| hbp_time | input | HW | Horizontal back porch in byte clocks |
| hline_time | input | HW | Total line length in byte clocks |
| pkt_size | input | PW | Active width in pixels |
| vsa_lines | input | VW | Vertical sync lines |
| vbp_lines | input | VW | Vertical back porch lines |
| vact_lines | input | VW | Active lines |
| vfp_lines | input | VW | Vertical front porch lines |
| vid_on | output | 1 | Timing is running |
| h_phase | output | 2 | Horizontal phase code |
| v_phase | output | 2 | Vertical period code |
| de | output | 1 | Active pixel region |
| act_pixels | output | PW | Packet width on active lines, else 0 |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| frame_start | output | 1 | First byte clock of a frame |

## Verification
Every output is decoded by combinational logic from the count registers and the live inputs. A change of `power_up` or `cmd_mode` therefore shows on the outputs in the same cycle. The counters move by one byte clock at each rising edge.

The bench reference model advances its line, period and byte-accumulator state at the rising edge, using the inputs that were held steady across that edge. Stimulus changes 1 ns after a rising edge, and every output is compared with the model at the falling edge that follows. This makes each comparison land exactly in the cycle in which the result is due, with no offset. Settings change only while the block is idle, so each run starts from a known first byte clock of a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } vtg_phase_e;

   typedef enum logic [1:0] {
      VT_PULSE   = 2'd0,
      VT_EVENT   = 2'd1,
      VT_BURST_A = 2'd2,
      VT_BURST_B = 2'd3
   } vtg_vmode_e;

   localparam int POL_HS_BIT = 2;
   localparam int POL_VS_BIT = 1;
   localparam int NUM_PERIODS = 4;

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount
   import vtg_pkg::*;
#(
   parameter int HW        = 12,
   parameter int PW        = 12,
   parameter int LANE_W    = 2,
   parameter int BPP_BYTES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HW-1:0]     hsa_time,
   input  logic [HW-1:0]     hbp_time,
   input  logic [HW-1:0]     hline_time,
   input  logic [PW-1:0]     pkt_size,
   input  logic [LANE_W-1:0] lane_sel,
   output logic [HW-1:0]     h_cnt,
   output vtg_phase_e        h_phase,
   output logic              line_end
);

   localparam int ACC_W = PW + $clog2(BPP_BYTES) + 1;

   if (HW < 2) begin : g_bad_hw
      $error("vtg_hcount: HW must be at least 2");
   end
   if (BPP_BYTES < 1) begin : g_bad_bpp
      $error("vtg_hcount: BPP_BYTES must be positive");
   end

   logic [HW-1:0]    cnt_q;
   logic [ACC_W-1:0] acc_q;
   logic [HW:0]      line_len;
   logic [HW:0]      sync_end;
   logic [HW:0]      bp_end;
   logic [ACC_W-1:0] need_bytes;
   logic [ACC_W-1:0] lane_step;

   assign line_len   = (hline_time == '0) ? (HW+1)'(1) : {1'b0, hline_time};
   assign sync_end   = {1'b0, hsa_time};
   assign bp_end     = {1'b0, hsa_time} + {1'b0, hbp_time};
   assign need_bytes = ACC_W'(pkt_size) * ACC_W'(BPP_BYTES);
   assign lane_step  = ACC_W'(lane_sel) + ACC_W'(1);

   assign line_end = run && (({1'b0, cnt_q} + (HW+1)'(1)) >= line_len);

   always_comb begin
      if ({1'b0, cnt_q} < sync_end)      h_phase = PH_SYNC;
      else if ({1'b0, cnt_q} < bp_end)   h_phase = PH_BACK;
      else if (acc_q < need_bytes)       h_phase = PH_ACT;
      else                               h_phase = PH_FRONT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (!run || line_end) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else begin
         cnt_q <= cnt_q + HW'(1);
         if (h_phase == PH_ACT) acc_q <= acc_q + lane_step;
      end
   end

   assign h_cnt = cnt_q;

   // R2: the count never reaches the programmed line length
   a_r2_cnt_below_line: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ({1'b0, h_cnt} < line_len));

   // R3: inside a line the phase only moves forward
   a_r3_phase_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !line_end) |=> (!run || (h_phase >= $past(h_phase))));

   // R1: idle cycles leave the horizontal count at zero
   a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (h_cnt == '0));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
   import vtg_pkg::*;
#(
   parameter int VW        = 11,
   parameter int VSA_LIMIT = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          line_end,
   input  logic [VW-1:0] vsa_lines,
   input  logic [VW-1:0] vbp_lines,
   input  logic [VW-1:0] vact_lines,
   input  logic [VW-1:0] vfp_lines,
   output vtg_phase_e    v_phase,
   output logic [VW-1:0] v_line,
   output logic          first_line
);

   if (VSA_LIMIT >= (1 << VW)) begin : g_bad_limit
      $error("vtg_vcount: VSA_LIMIT does not fit in VW bits");
   end

   logic [VW-1:0] per_cnt [NUM_PERIODS];
   logic [1:0]    ph_q;
   logic [1:0]    ph_nxt;
   logic [1:0]    ph_init;
   logic [VW-1:0] line_q;
   logic          first_q;
   logic          wrap;
   logic          period_done;

   always_comb begin
      per_cnt[0] = (vsa_lines > VW'(VSA_LIMIT)) ? VW'(VSA_LIMIT) : vsa_lines;
      per_cnt[1] = vbp_lines;
      per_cnt[2] = vact_lines;
      per_cnt[3] = vfp_lines;
   end

   // next non-empty period after the current one (itself if none other)
   always_comb begin
      logic       found;
      logic [1:0] cand;
      found  = 1'b0;
      ph_nxt = ph_q;
      for (int k = 1; k <= NUM_PERIODS; k++) begin
         cand = ph_q + 2'(k);
         if (!found && (per_cnt[cand] != '0)) begin
            ph_nxt = cand;
            found  = 1'b1;
         end
      end
   end

   // first non-empty period of a frame
   always_comb begin
      logic found;
      found   = 1'b0;
      ph_init = 2'd0;
      for (int k = 0; k < NUM_PERIODS; k++) begin
         if (!found && (per_cnt[k] != '0)) begin
            ph_init = 2'(k);
            found   = 1'b1;
         end
      end
   end

   assign wrap        = (ph_nxt <= ph_q);
   assign period_done = (({1'b0, line_q} + (VW+1)'(1)) >= {1'b0, per_cnt[ph_q]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= 2'd0;
         line_q  <= '0;
         first_q <= 1'b1;
      end else if (!run) begin
         ph_q    <= ph_init;
         line_q  <= '0;
         first_q <= 1'b1;
      end else if (line_end) begin
         if (period_done) begin
            ph_q    <= ph_nxt;
            line_q  <= '0;
            first_q <= wrap;
         end else begin
            line_q  <= line_q + VW'(1);
            first_q <= 1'b0;
         end
      end
   end

   assign v_phase    = vtg_phase_e'(ph_q);
   assign v_line     = line_q;
   assign first_line = first_q;

   // R6: vertical sync never runs past its limit
   a_r6_vsa_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (v_phase == PH_SYNC)) |-> (v_line < VW'(VSA_LIMIT)));

   // R5: the vertical period only changes at a line boundary
   a_r5_period_holds_midline: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !line_end) |=> (!run || $stable(v_phase)));

endmodule

// File: rtl/vtg_sync_fmt.sv
module vtg_sync_fmt
   import vtg_pkg::*;
#(
   parameter bit EVENTS_EN = 1'b1
) (
   input  logic       run,
   input  logic [1:0] vmode,
   input  logic       hs_inv,
   input  logic       vs_inv,
   input  vtg_phase_e h_phase,
   input  vtg_phase_e v_phase,
   input  logic       h_start,
   input  logic       v_first_line,
   input  logic       frame_first,
   output logic       hsync,
   output logic       vsync,
   output logic       frame_start
);

   logic ev;
   logic hs_raw;
   logic vs_raw;

   if (EVENTS_EN) begin : g_events
      assign ev = (vmode == VT_EVENT);
   end else begin : g_pulses_only
      assign ev = 1'b0;
   end

   always_comb begin
      if (ev) begin
         hs_raw = run && h_start;
         vs_raw = run && (v_phase == PH_SYNC) && v_first_line && h_start;
      end else begin
         hs_raw = run && (h_phase == PH_SYNC);
         vs_raw = run && (v_phase == PH_SYNC);
      end
   end

   assign hsync       = hs_raw ^ hs_inv;
   assign vsync       = vs_raw ^ vs_inv;
   assign frame_start = run && frame_first && h_start;

endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
   import vtg_pkg::*;
#(
   parameter int HW        = 12,
   parameter int VW        = 11,
   parameter int PW        = 12,
   parameter int LANE_W    = 2,
   parameter int BPP_BYTES = 3,
   parameter int VSA_LIMIT = 15,
   parameter bit EVENTS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_up,
   input  logic              cmd_mode,
   input  logic [1:0]        vmode,
   input  logic [2:0]        pol_cfg,
   input  logic [LANE_W-1:0] lane_sel,
   input  logic [HW-1:0]     hsa_time,
   input  logic [HW-1:0]     hbp_time,
   input  logic [HW-1:0]     hline_time,
   input  logic [PW-1:0]     pkt_size,
   input  logic [VW-1:0]     vsa_lines,
   input  logic [VW-1:0]     vbp_lines,
   input  logic [VW-1:0]     vact_lines,
   input  logic [VW-1:0]     vfp_lines,
   output logic              vid_on,
   output logic [1:0]        h_phase,
   output logic [1:0]        v_phase,
   output logic              de,
   output logic [PW-1:0]     act_pixels,
   output logic              hsync,
   output logic              vsync,
   output logic              frame_start
);

   if (LANE_W < 1) begin : g_bad_lane
      $error("dsi_vid_timing: LANE_W must be at least 1");
   end

   logic          run;
   logic [HW-1:0] h_cnt;
   vtg_phase_e    h_ph;
   vtg_phase_e    v_ph;
   logic          line_end;
   logic [VW-1:0] v_line;
   logic          first_line;
   logic          unused_pol;

   assign run        = power_up && !cmd_mode;
   assign unused_pol = pol_cfg[0];

   vtg_hcount #(
      .HW(HW), .PW(PW), .LANE_W(LANE_W), .BPP_BYTES(BPP_BYTES)
   ) hcount_i (
      .clk(clk), .rst_n(rst_n), .run(run),
      .hsa_time(hsa_time), .hbp_time(hbp_time), .hline_time(hline_time),
      .pkt_size(pkt_size), .lane_sel(lane_sel),
      .h_cnt(h_cnt), .h_phase(h_ph), .line_end(line_end)
   );

   vtg_vcount #(
      .VW(VW), .VSA_LIMIT(VSA_LIMIT)
   ) vcount_i (
      .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
      .vsa_lines(vsa_lines), .vbp_lines(vbp_lines),
      .vact_lines(vact_lines), .vfp_lines(vfp_lines),
      .v_phase(v_ph), .v_line(v_line), .first_line(first_line)
   );

   vtg_sync_fmt #(
      .EVENTS_EN(EVENTS_EN)
   ) sync_fmt_i (
      .run(run), .vmode(vmode),
      .hs_inv(pol_cfg[POL_HS_BIT]), .vs_inv(pol_cfg[POL_VS_BIT]),
      .h_phase(h_ph), .v_phase(v_ph),
      .h_start(h_cnt == '0), .v_first_line(v_line == '0),
      .frame_first(first_line),
      .hsync(hsync), .vsync(vsync), .frame_start(frame_start)
   );

   assign vid_on     = run;
   assign h_phase    = run ? h_ph : PH_SYNC;
   assign v_phase    = run ? v_ph : PH_SYNC;
   assign de         = run && (v_ph == PH_ACT) && (h_ph == PH_ACT);
   assign act_pixels = (run && (v_ph == PH_ACT)) ? pkt_size : '0;

endmodule

// File: tb/dsi_vid_timing_tb_top.sv
`timescale 1ns/1ps
module dsi_vid_timing_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        power_up = 1'b0;
   logic        cmd_mode = 1'b0;
   logic [1:0]  vmode = 2'd0;
   logic [2:0]  pol_cfg = 3'd0;
   logic [1:0]  lane_sel = 2'd0;
   logic [11:0] hsa_time = '0, hbp_time = '0, hline_time = 12'd8;
   logic [11:0] pkt_size = '0;
   logic [10:0] vsa_lines = 11'd1, vbp_lines = '0, vact_lines = 11'd1, vfp_lines = '0;
   logic        vid_on, de, hsync, vsync, frame_start;
   logic [1:0]  h_phase, v_phase;
   logic [11:0] act_pixels;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   int m_hc, m_acc, m_vl, m_vph;
   bit m_first;

   always #2.5 clk = ~clk;

   dsi_vid_timing dut_i (
      .clk(clk), .rst_n(rst_n), .power_up(power_up), .cmd_mode(cmd_mode),
      .vmode(vmode), .pol_cfg(pol_cfg), .lane_sel(lane_sel),
      .hsa_time(hsa_time), .hbp_time(hbp_time), .hline_time(hline_time),
      .pkt_size(pkt_size), .vsa_lines(vsa_lines), .vbp_lines(vbp_lines),
      .vact_lines(vact_lines), .vfp_lines(vfp_lines),
      .vid_on(vid_on), .h_phase(h_phase), .v_phase(v_phase), .de(de),
      .act_pixels(act_pixels), .hsync(hsync), .vsync(vsync),
      .frame_start(frame_start)
   );

   function automatic bit m_run();
      return power_up && !cmd_mode;
   endfunction

   function automatic int vcnt(int p);
      case (p)
         0: return (vsa_lines > 15) ? 15 : int'(vsa_lines);
         1: return int'(vbp_lines);
         2: return int'(vact_lines);
         default: return int'(vfp_lines);
      endcase
   endfunction

   function automatic int m_hph();
      if (m_hc < hsa_time) return 0;
      if (m_hc < hsa_time + hbp_time) return 1;
      if (m_acc < pkt_size * 3) return 2;
      return 3;
   endfunction

   task automatic model_idle();
      m_hc = 0; m_acc = 0; m_vl = 0; m_first = 1; m_vph = 0;
      for (int k = 0; k < 4; k++) begin
         if (vcnt(k) != 0) begin m_vph = k; break; end
      end
   endtask

   task automatic model_step();
      int hl, ph, nxt;
      hl = (hline_time == 0) ? 1 : int'(hline_time);
      ph = m_hph();
      if (m_hc + 1 >= hl) begin
         m_hc = 0; m_acc = 0;
         if (m_vl + 1 >= vcnt(m_vph)) begin
            nxt = m_vph;
            for (int k = 1; k <= 4; k++) begin
               if (vcnt((m_vph + k) % 4) != 0) begin nxt = (m_vph + k) % 4; break; end
            end
            m_first = (nxt <= m_vph);
            m_vph = nxt; m_vl = 0;
         end else begin
            m_vl++; m_first = 0;
         end
      end else begin
         if (ph == 2) m_acc += int'(lane_sel) + 1;
         m_hc++;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hc = 0; m_acc = 0; m_vl = 0; m_vph = 0; m_first = 1;
      end else if (!m_run()) model_idle();
      else model_step();
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit r, e_de, e_hs, e_vs, e_fs;
         int e_h, e_v, e_pix;
         string th, tv;
         r     = m_run();
         e_h   = r ? m_hph() : 0;
         e_v   = r ? m_vph : 0;
         e_de  = r && m_vph == 2 && m_hph() == 2;
         e_pix = (r && m_vph == 2) ? int'(pkt_size) : 0;
         if (vmode == 2'd1) begin
            e_hs = r && m_hc == 0;
            e_vs = r && m_vph == 0 && m_vl == 0 && m_hc == 0;
         end else begin
            e_hs = r && m_hph() == 0;
            e_vs = r && m_vph == 0;
         end
         e_hs = e_hs ^ pol_cfg[2];
         e_vs = e_vs ^ pol_cfg[1];
         e_fs = r && m_first && m_hc == 0;
         if (!r) th = "R1"; else if (e_h >= 2) th = "R4"; else if (m_hc == 0) th = "R2"; else th = "R3";
         if (!r) tv = "R1"; else if (vsa_lines > 15) tv = "R6"; else tv = "R5";
         chk(vid_on == r, "R1", "vid_on", vid_on, r);
         chk(h_phase == e_h, th, "h_phase", h_phase, e_h);
         chk(v_phase == e_v, tv, "v_phase", v_phase, e_v);
         chk(de == e_de, r ? "R7" : "R1", "de", de, e_de);
         chk(act_pixels == e_pix, r ? "R7" : "R1", "act_pixels", act_pixels, e_pix);
         chk(hsync == e_hs, pol_cfg[2] ? "R9" : "R8", "hsync", hsync, e_hs);
         chk(vsync == e_vs, pol_cfg[1] ? "R9" : "R8", "vsync", vsync, e_vs);
         chk(frame_start == e_fs, "R10", "frame_start", frame_start, e_fs);
      end
   end

   task automatic setup(input int hsa, input int hbp, input int hl, input int pkt,
                        input int lane, input int vsa, input int vbp, input int vact,
                        input int vfp, input int mode, input int pol);
      @(posedge clk); #1;
      power_up = 0; cmd_mode = 0;
      hsa_time = 12'(hsa); hbp_time = 12'(hbp); hline_time = 12'(hl);
      pkt_size = 12'(pkt); lane_sel = 2'(lane);
      vsa_lines = 11'(vsa); vbp_lines = 11'(vbp); vact_lines = 11'(vact); vfp_lines = 11'(vfp);
      vmode = 2'(mode); pol_cfg = 3'(pol);
      repeat (3) @(posedge clk); #1;
      power_up = 1;
   endtask

   task automatic run_for(input int n);
      repeat (n) @(posedge clk); #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      bad++; total++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // reset state (R1)
      repeat (3) @(negedge clk);
      chk(vid_on == 0, "R1", "reset vid_on", vid_on, 0);
      chk(de == 0, "R1", "reset de", de, 0);
      chk(frame_start == 0, "R1", "reset frame_start", frame_start, 0);
      chk(hsync == 0 && vsync == 0, "R1", "reset syncs", {hsync, vsync}, 0);
      @(posedge clk); #1; rst_n = 1;
      // R3 R4 R5 basic pulse frame, 2 lanes, 12 bytes -> 6 active clocks
      setup(2, 3, 20, 4, 1, 2, 1, 3, 2, 0, 0);
      run_for(500);
      // R8 R9 sync events, both inverted, 4 lanes, 15 bytes -> 4 clocks
      setup(3, 2, 16, 5, 3, 1, 2, 2, 1, 1, 6);
      run_for(300);
      // R4 truncation at line end
      setup(1, 1, 10, 100, 0, 1, 1, 2, 1, 0, 0);
      run_for(150);
      // R6 sync clamp with skipped back porch (R5)
      setup(1, 1, 6, 1, 0, 20, 0, 2, 1, 0, 2);
      run_for(250);
      // R10 empty sync period: frame begins in back porch
      setup(0, 1, 4, 1, 2, 0, 2, 1, 0, 1, 0);
      run_for(80);
      // R2 zero line length, all periods empty
      setup(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_for(20);
      // R1 command mode holds idle, then mid-run power drop restarts
      setup(2, 2, 12, 2, 1, 1, 1, 2, 1, 0, 4);
      cmd_mode = 1;
      run_for(30);
      cmd_mode = 0;
      run_for(57);
      power_up = 0;
      run_for(5);
      power_up = 1;
      run_for(100);
      // R8 burst types behave as pulses; R9 bit 0 ignored
      setup(2, 1, 14, 3, 2, 2, 1, 2, 1, 2, 1);
      run_for(150);
      setup(2, 1, 14, 3, 2, 2, 1, 2, 1, 3, 1);
      run_for(150);
      finish_run();
   end

endmodule